// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. Within one long cycle the fetched word is decoded, its source registers are read, the arithmetic unit computes a sum or a signed comparison, data memory is read or written, and the destination register is updated. The core holds the program counter, a 32-entry general-purpose register file, the arithmetic unit, the immediate sign extender and the steering multiplexers. Both memories sit outside the core. Instruction memory is read combinationally. Data memory is read combinationally and written on the clock edge.

It recognises four instructions: register add, set-if-less-than against an immediate, load word and store word. Any other word is treated as a no-op that only moves the program counter on. The 32-bit instruction fields are:

- opcode in bits 31:26
- first source register in bits 25:21
- second source or immediate-form destination in bits 20:16
- register-form destination in bits 15:11
- shift amount in bits 10:6
- function code in bits 5:0
- 16-bit immediate in bits 15:0

Top module: `onecycle_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears every register of the register file.
- R2: Outside reset the program counter advances by 4 on every clock edge, and `imem_addr` always equals the program counter.
- R3: A word with opcode 0x00, function code 0x20 and shift amount 0 writes the sum, modulo 2^32, of the registers named in bits 25:21 and 20:16 into the register named in bits 15:11. It does not write data memory.
- R4: Opcode 0x0A compares the register named in bits 25:21 with the sign-extended immediate, both as signed values. It writes 1 into the register named in bits 20:16 if the register value is smaller, and 0 otherwise.
- R5: Opcode 0x2B raises `dmem_we` for that cycle only. It drives `dmem_addr` with the base register (bits 25:21) plus the sign-extended immediate, and drives `dmem_wdata` with the register named in bits 20:16. It writes no register.
- R6: Opcode 0x23 reads data memory at the base register plus the sign-extended immediate, and writes the returned word into the register named in bits 20:16.
- R7: Writes to register 0 are discarded, and register 0 always reads as zero.
- R8: Any other opcode, or an opcode-0x00 word with a function code other than 0x20 or a non-zero shift amount, writes neither a register nor data memory. The program counter still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for data memory (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 32 | Word read combinationally at `dmem_addr` |

## Verification
A load whose base register was itself filled by the previous load reads and writes the register file in the same cycle. Its address is computed from a freshly written register, while a later store exposes the loaded value at the store data port. The bench provokes this with a load whose base is set by the preceding load, followed by a store through that same base with a different offset. A behavioural model compares the fetch address, the write enable, the store address and the store data on every cycle. At the end, the bench compares fixed expected words in data memory that were worked out by hand for each instruction class, including the equal-value comparison boundary and a signed-versus-unsigned comparison case.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 16;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_LOAD = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STOR = 6'h2B;
    localparam logic [5:0]       FN_ADD   = 6'h20;

    typedef enum logic [0:0] {
        ALU_ADD = 1'b0,
        ALU_SLT = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;      // destination register is updated
        logic    dst_is_rd;   // destination taken from bits 15:11
        logic    b_is_imm;    // second operand is the extended immediate
        alu_op_e alu_op;
        logic    mem_we;      // data memory written
        logic    wb_mem;      // write-back value comes from data memory
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{reg_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0,
                                   alu_op: ALU_ADD, mem_we: 1'b0, wb_mem: 1'b0};

endpackage

// File: rtl/oc_decode.sv
module oc_decode
    import oc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic [RIDX_W-1:0]  src_a,
    output logic [RIDX_W-1:0]  src_b,
    output logic [RIDX_W-1:0]  dst_r,
    output logic [IMM_W-1:0]   imm
);

    logic [OPC_W-1:0] opc;
    logic [4:0]       shamt;
    logic [5:0]       fn;

    assign opc   = instr[31:26];
    assign src_a = instr[25:21];
    assign src_b = instr[20:16];
    assign dst_r = instr[15:11];
    assign shamt = instr[10:6];
    assign fn    = instr[5:0];
    assign imm   = instr[15:0];

    always_comb begin
        ctrl = CTRL_NOP;
        unique case (opc)
            OPC_REG: begin
                // R3 / R8: only the plain add form is accepted
                if (fn == FN_ADD && shamt == '0) begin
                    ctrl.reg_we    = 1'b1;
                    ctrl.dst_is_rd = 1'b1;
                end
            end
            OPC_SLTI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.alu_op   = ALU_SLT;
            end
            OPC_LOAD: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.wb_mem   = 1'b1;
            end
            OPC_STOR: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/oc_regfile.sv
module oc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] ra_idx,
    input  logic [$clog2(NREG)-1:0] rb_idx,
    output logic [XLEN-1:0]         ra_val,
    output logic [XLEN-1:0]         rb_val,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] w_idx,
    input  logic [XLEN-1:0]         w_val
);

    logic [NREG-1:0][XLEN-1:0] regs_d;
    logic [NREG-1:0][XLEN-1:0] regs_q;

    // R7: entry 0 never takes a write
    assign regs_d[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_entry
        assign regs_d[g] = (we && w_idx == g) ? w_val : regs_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;     // R1
        else     regs_q <= regs_d;
    end

    assign ra_val = regs_q[ra_idx];
    assign rb_val = regs_q[rb_idx];

endmodule

// File: rtl/oc_alu.sv
module oc_alu
    import oc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);

    logic lt;

    assign lt = $signed(a) < $signed(b);

    always_comb begin
        unique case (op)
            ALU_SLT: y = {{(XLEN-1){1'b0}}, lt};
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/onecycle_core.sv
module onecycle_core
    import oc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic               clk,
    input  logic               rst,
    output logic [XLEN-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [XLEN-1:0]    dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               dmem_we,
    input  logic [XLEN-1:0]    dmem_rdata
);

    localparam int          AW      = $clog2(NREG);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(XLEN / 8);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t state_d, state_q;

    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rs_f, rt_f, rd_f;
    logic [IMM_W-1:0]  imm_f;
    logic [AW-1:0]     rs_idx, rt_idx, wr_idx;
    logic [XLEN-1:0]   rs_val, rt_val, imm_x, alu_b, alu_y, wr_val;

    // fetch: R2
    always_comb begin
        state_d    = state_q;
        state_d.pc = state_q.pc + PC_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;    // R1
        else     state_q <= state_d;
    end

    assign imem_addr = state_q.pc;

    // decode and register read
    oc_decode u_dec (
        .instr (imem_data),
        .ctrl  (ctrl),
        .src_a (rs_f),
        .src_b (rt_f),
        .dst_r (rd_f),
        .imm   (imm_f)
    );

    assign rs_idx = rs_f[AW-1:0];
    assign rt_idx = rt_f[AW-1:0];
    assign wr_idx = ctrl.dst_is_rd ? rd_f[AW-1:0] : rt_f[AW-1:0];
    assign imm_x  = {{(XLEN-IMM_W){imm_f[IMM_W-1]}}, imm_f};

    oc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_idx (rs_idx),
        .rb_idx (rt_idx),
        .ra_val (rs_val),
        .rb_val (rt_val),
        .we     (ctrl.reg_we),
        .w_idx  (wr_idx),
        .w_val  (wr_val)
    );

    // execute
    assign alu_b = ctrl.b_is_imm ? imm_x : rt_val;

    oc_alu #(.XLEN(XLEN)) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    // memory access: R5, R6
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

    // write-back
    assign wr_val = ctrl.wb_mem ? dmem_rdata : alu_y;

endmodule

// File: rtl/oc_checker.sv
module oc_checker #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [31:0]     imem_data,
    input logic            dmem_we,
    input logic [AW-1:0]   rs_idx,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] alu_y
);

    assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr == '0));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (imem_addr == $past(imem_addr) + XLEN'(4)));

    assert_store_only_R5: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (imem_data[31:26] == 6'h2B));

    assert_slt_bool_R4: assert property (@(posedge clk) disable iff (rst)
        (imem_data[31:26] == 6'h0A) |-> (alu_y[XLEN-1:1] == '0));

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == '0) |-> (rs_val == '0));

endmodule

bind onecycle_core oc_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .rs_idx    (rs_idx),
    .rs_val    (rs_val),
    .alu_y     (alu_y)
);

// File: tb/tb_onecycle_core.sv
module tb_onecycle_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];

    int checks = 0;
    int errs   = 0;

    logic [31:0] mpc;
    logic [31:0] mreg [32];
    logic [31:0] mmem [256];

    always #10 clk = ~clk;   // 50 MHz

    onecycle_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] rd, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] sh,
                                          input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic mwrite(input logic [4:0] idx, input logic [31:0] v);
        if (idx != 5'd0) mreg[idx] = v;
    endtask

    // behavioural model: compare ports for this cycle, then advance one instruction
    task automatic model_step();
        logic [31:0] w, immx, ea;
        logic [5:0]  op;
        logic [4:0]  rs, rt, rd, sh;
        w    = imem[mpc[9:2]];
        op   = w[31:26];
        rs   = w[25:21];
        rt   = w[20:16];
        rd   = w[15:11];
        sh   = w[10:6];
        immx = {{16{w[15]}}, w[15:0]};
        ea   = mreg[rs] + immx;
        chk("R2 fetch address", imem_addr, mpc);
        chk("R5 store enable", {31'd0, dmem_we}, {31'd0, op == 6'h2B});
        if (op == 6'h2B) begin
            chk("R5 store address", dmem_addr, ea);
            chk("R5 store data", dmem_wdata, mreg[rt]);
        end
        case (op)
            6'h00: if (w[5:0] == 6'h20 && sh == 5'd0) mwrite(rd, mreg[rs] + mreg[rt]);
            6'h0A: mwrite(rt, ($signed(mreg[rs]) < $signed(immx)) ? 32'd1 : 32'd0);
            6'h23: mwrite(rt, mmem[ea[9:2]]);
            6'h2B: mmem[ea[9:2]] = mreg[rt];
            default: ;
        endcase
        mpc = mpc + 32'd4;
    endtask

    task automatic model_reset();
        mpc = 32'd0;
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            imem[i] = 32'd0;
            dmem[i] = 32'd0;
        end
        dmem[0] = 32'd5;
        dmem[1] = 32'hFFFF_FFF0;
        dmem[2] = 32'h7000_0000;
        dmem[3] = 32'h1234_5678;
        dmem[4] = 32'd16;
        for (int i = 16; i < 28; i++) dmem[i] = 32'hDEAD_0000 + i;
        imem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
        imem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
        imem[2]  = enc_r(5'd3, 5'd1, 5'd2, 5'd0, 6'h20);
        imem[3]  = enc_i(6'h2B, 5'd0, 5'd3, 16'd64);
        imem[4]  = enc_i(6'h0A, 5'd2, 5'd4, 16'hFFF1);
        imem[5]  = enc_i(6'h0A, 5'd1, 5'd5, 16'd5);
        imem[6]  = enc_i(6'h0A, 5'd1, 5'd6, 16'd6);
        imem[7]  = enc_i(6'h2B, 5'd0, 5'd4, 16'd68);
        imem[8]  = enc_i(6'h2B, 5'd0, 5'd5, 16'd72);
        imem[9]  = enc_i(6'h2B, 5'd0, 5'd6, 16'd76);
        imem[10] = enc_r(5'd0, 5'd1, 5'd1, 5'd0, 6'h20);
        imem[11] = enc_i(6'h2B, 5'd0, 5'd0, 16'd80);
        imem[12] = enc_i(6'h23, 5'd0, 5'd0, 16'd12);
        imem[13] = enc_i(6'h2B, 5'd0, 5'd0, 16'd84);
        imem[14] = enc_i(6'h23, 5'd0, 5'd10, 16'd16);
        imem[15] = enc_i(6'h23, 5'd10, 5'd11, 16'hFFFC);
        imem[16] = enc_i(6'h2B, 5'd0, 5'd11, 16'd88);
        imem[17] = enc_i(6'h2B, 5'd10, 5'd11, 16'd8);
        imem[18] = enc_i(6'h23, 5'd0, 5'd13, 16'd8);
        imem[19] = enc_i(6'h0A, 5'd13, 5'd14, 16'hFFFF);
        imem[20] = enc_i(6'h2B, 5'd0, 5'd14, 16'd92);
        imem[21] = enc_r(5'd15, 5'd13, 5'd13, 5'd0, 6'h20);
        imem[22] = enc_i(6'h2B, 5'd0, 5'd15, 16'd96);
        imem[23] = enc_i(6'h3F, 5'd1, 5'd3, 16'h0040);
        imem[24] = enc_r(5'd3, 5'd1, 5'd1, 5'd0, 6'h22);
        imem[25] = enc_r(5'd3, 5'd1, 5'd1, 5'd1, 6'h20);
        imem[26] = enc_i(6'h2B, 5'd0, 5'd3, 16'd100);
        imem[27] = enc_i(6'h2B, 5'd0, 5'd20, 16'd104);
        for (int i = 0; i < 256; i++) mmem[i] = dmem[i];
        model_reset();

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc after reset", imem_addr, 32'd0);
        rst = 1'b0;
        for (int c = 0; c < 34; c++) begin
            model_step();
            @(negedge clk);
        end

        chk("R3 add result stored", dmem[16], 32'hFFFF_FFF5);
        chk("R4 slti negative less", dmem[17], 32'd1);
        chk("R4 slti equal gives 0", dmem[18], 32'd0);
        chk("R4 slti greater imm", dmem[19], 32'd1);
        chk("R7 add into r0 discarded", dmem[20], 32'd0);
        chk("R7 load into r0 discarded", dmem[21], 32'd0);
        chk("R6 load negative offset", dmem[22], 32'h1234_5678);
        chk("R5 store via base+offset", dmem[6], 32'h1234_5678);
        chk("R4 slti signed compare", dmem[23], 32'd0);
        chk("R3 add wraps", dmem[24], 32'hE000_0000);
        chk("R8 no-op words keep r3", dmem[25], 32'hFFFF_FFF5);
        chk("R1 untouched register zero", dmem[26], 32'd0);
        chk("R8 unwritten word kept", dmem[27], 32'hDEAD_001B);

        rst = 1'b1;
        @(negedge clk);
        chk("R1 pc after mid-run reset", imem_addr, 32'd0);
        rst = 1'b0;
        model_reset();
        for (int i = 0; i < 256; i++) mmem[i] = dmem[i];
        for (int c = 0; c < 5; c++) begin
            model_step();
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 5000, 50);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule